// File: doc/BRIEF.md
# Invalid Block Table Scanner

This block runs once after reset and builds a one-bit-per-block table that marks unusable blocks in a NAND array. It starts at block 0 and moves up one block at a time to the last block. For each block it asks a generic page-read port for one byte from page 0 and then one byte from page 1. The byte it asks for is the marker column. The block is recorded as invalid when either byte is not the erased value FFh.

When the walk over all blocks ends, the block raises a completion flag. Other logic can then look up any block number and get its invalid flag back in the same cycle. The block also reports how many invalid blocks it holds, and raises an alert when that number goes above a set limit. A later program or erase failure can add further blocks to the table through a one-cycle mark input. Block 0 is always reported as valid, whatever the array returns for it and whatever is marked later.

Top module: `ibt_scanner`

## Requirements
- R1: After reset the scanner requests, in order, block 0 page 0, block 0 page 1, block 1 page 0, and so on up to page 1 of the last block. The row address sent for page p of block b is b*PAGES_PER_BLK + p (16 pages per block by default). The column sent is always MARK_COL (default 517). In total it makes 2*NUM_BLOCKS requests.
- R2: A block other than block 0 is recorded invalid when the byte returned for page 0 or for page 1 is not FFh (for example 00h or 7Fh). When both bytes are FFh the block stays valid. Bytes at other pages of the block are never read and cannot change the result.
- R3: Block 0 is always reported as valid. This holds even when its marker bytes read 00h and even when it is marked through the mark input.
- R4: A request stays asserted with a stable row and column until it is accepted. Only one request is outstanding at a time. Any response latency is tolerated.
- R5: scan_done rises in the cycle after the response for the last block is taken. It then stays high until reset, and no further requests are issued.
- R6: While scan_done is low, query_ready and query_bad are both 0. Once scan_done is high, query_ready is 1 and query_bad gives the table entry for query_blk in the same cycle, with no register in the path.
- R7: bad_count equals the number of blocks set in the table. bad_alert is 1 exactly when bad_count is greater than MAX_BAD (10 by default).
- R8: A one-cycle pulse on mark_valid sets the table entry for mark_blk at the next clock edge. bad_count goes up by one only when the entry was not already set. A pulse that names block 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the scan starts when it is released |
| rd_req_valid | output | 1 | A page-read request is pending |
| rd_req_ready | input | 1 | The read port accepts the request at this edge |
| rd_req_row | output | 14 | Row (page) address of the request |
| rd_req_col | output | 10 | Column of the marker byte |
| rd_rsp_valid | input | 1 | The response byte is valid |
| rd_rsp_data | input | 8 | The byte read from the marker column |
| mark_valid | input | 1 | Pulse that marks a block invalid at run time |
| mark_blk | input | 10 | Block to mark |
| query_blk | input | 10 | Block number to look up |
| query_ready | output | 1 | The table is complete and the lookup result is meaningful |
| query_bad | output | 1 | The looked-up block is invalid |
| scan_done | output | 1 | The scan has finished |
| bad_count | output | 11 | Number of invalid blocks in the table |
| bad_alert | output | 1 | bad_count is greater than MAX_BAD |

## Verification
A table entry, bad_count and bad_alert change at the clock edge that takes the page-1 response for a block, or at the edge that sees a mark pulse. The bench changes inputs on falling edges and reads results on the next falling edge, so each result is read one edge after its cause. query_bad has no register in its path, so the bench sets query_blk and reads the answer a short delay later within the same low half-cycle. scan_done is read by polling on falling edges. The bench checks the exact order of requests inside the read model as each request is accepted. It runs that check with immediate responses and again with the request port held back on some cycles and the response delayed by three cycles.

// File: rtl/ibt_pkg.sv
`timescale 1ns/1ps
package ibt_pkg;
    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DONE  = 2'd2
    } scan_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/ibt_walker.sv
`timescale 1ns/1ps
module ibt_walker
    import ibt_pkg::*;
#(
    parameter int NUM_BLOCKS    = 1024,
    parameter int PAGES_PER_BLK = 16,
    parameter int MARK_COL      = 517,
    parameter int COL_W         = 10
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    output logic                                            rd_req_valid,
    input  logic                                            rd_req_ready,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLK)-1:0] rd_req_row,
    output logic [COL_W-1:0]                                rd_req_col,
    input  logic                                            rd_rsp_valid,
    input  logic [7:0]                                      rd_rsp_data,
    output logic                                            rec_valid,
    output logic [$clog2(NUM_BLOCKS)-1:0]                   rec_blk,
    output logic                                            rec_bad,
    output logic                                            done
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int ROW_W = BLK_W + $clog2(PAGES_PER_BLK);

    typedef struct packed {
        scan_state_e      st;
        logic [BLK_W-1:0] blk;
        logic             pg;
        logic             bad;
    } walk_t;

    walk_t cur_q, nxt_d;
    logic  flag_d;

    always_comb begin
        nxt_d     = cur_q;
        rec_valid = 1'b0;
        rec_bad   = 1'b0;
        flag_d    = cur_q.bad | (rd_rsp_data != ERASED_BYTE);
        case (cur_q.st)
            ST_ISSUE: begin
                if (rd_req_ready) nxt_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rsp_valid) begin
                    if (!cur_q.pg) begin
                        nxt_d.pg  = 1'b1;
                        nxt_d.bad = flag_d;
                        nxt_d.st  = ST_ISSUE;
                    end else begin
                        rec_valid = 1'b1;
                        rec_bad   = flag_d && (cur_q.blk != '0);
                        nxt_d.pg  = 1'b0;
                        nxt_d.bad = 1'b0;
                        if (cur_q.blk == BLK_W'(NUM_BLOCKS - 1)) begin
                            nxt_d.st = ST_DONE;
                        end else begin
                            nxt_d.blk = cur_q.blk + 1'b1;
                            nxt_d.st  = ST_ISSUE;
                        end
                    end
                end
            end
            default: nxt_d = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_ISSUE, blk: '0, pg: 1'b0, bad: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_req_valid = (cur_q.st == ST_ISSUE);
    assign rd_req_row   = ROW_W'(cur_q.blk) * ROW_W'(PAGES_PER_BLK) + ROW_W'(cur_q.pg);
    assign rd_req_col   = COL_W'(MARK_COL);
    assign rec_blk      = cur_q.blk;
    assign done         = (cur_q.st == ST_DONE);
endmodule

// File: rtl/ibt_table.sv
`timescale 1ns/1ps
module ibt_table #(
    parameter int NUM_BLOCKS = 1024,
    parameter int MAX_BAD    = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rec_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0]     rec_blk,
    input  logic                              rec_bad,
    input  logic                              mark_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0]     mark_blk,
    input  logic                              ready,
    input  logic [$clog2(NUM_BLOCKS)-1:0]     query_blk,
    output logic                              query_bad,
    output logic [$clog2(NUM_BLOCKS+1)-1:0]   bad_count,
    output logic                              bad_alert
);
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1);

    typedef struct packed {
        logic [NUM_BLOCKS-1:0] map;
        logic [CNT_W-1:0]      cnt;
    } tbl_t;

    tbl_t cur_q, nxt_d;
    logic set_scan_d, set_mark_d;

    always_comb begin
        nxt_d      = cur_q;
        set_scan_d = rec_valid && rec_bad && (rec_blk != '0)
                     && (int'(rec_blk) < NUM_BLOCKS) && !cur_q.map[rec_blk];
        set_mark_d = mark_valid && (mark_blk != '0)
                     && (int'(mark_blk) < NUM_BLOCKS) && !cur_q.map[mark_blk]
                     && !(set_scan_d && (rec_blk == mark_blk));
        if (set_scan_d) nxt_d.map[rec_blk]  = 1'b1;
        if (set_mark_d) nxt_d.map[mark_blk] = 1'b1;
        nxt_d.cnt = cur_q.cnt + CNT_W'(set_scan_d) + CNT_W'(set_mark_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign query_bad = ready && (int'(query_blk) < NUM_BLOCKS) && cur_q.map[query_blk];
    assign bad_count = cur_q.cnt;
    assign bad_alert = (cur_q.cnt > CNT_W'(MAX_BAD));
endmodule

// File: rtl/ibt_scanner.sv
`timescale 1ns/1ps
module ibt_scanner #(
    parameter int NUM_BLOCKS    = 1024,
    parameter int PAGES_PER_BLK = 16,
    parameter int MARK_COL      = 517,
    parameter int COL_W         = 10,
    parameter int MAX_BAD       = 10
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    output logic                                            rd_req_valid,
    input  logic                                            rd_req_ready,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLK)-1:0] rd_req_row,
    output logic [COL_W-1:0]                                rd_req_col,
    input  logic                                            rd_rsp_valid,
    input  logic [7:0]                                      rd_rsp_data,
    input  logic                                            mark_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0]                   mark_blk,
    input  logic [$clog2(NUM_BLOCKS)-1:0]                   query_blk,
    output logic                                            query_ready,
    output logic                                            query_bad,
    output logic                                            scan_done,
    output logic [$clog2(NUM_BLOCKS+1)-1:0]                 bad_count,
    output logic                                            bad_alert
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    logic             rec_valid;
    logic [BLK_W-1:0] rec_blk;
    logic             rec_bad;

    ibt_walker #(
        .NUM_BLOCKS   (NUM_BLOCKS),
        .PAGES_PER_BLK(PAGES_PER_BLK),
        .MARK_COL     (MARK_COL),
        .COL_W        (COL_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready),
        .rd_req_row  (rd_req_row),
        .rd_req_col  (rd_req_col),
        .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data (rd_rsp_data),
        .rec_valid   (rec_valid),
        .rec_blk     (rec_blk),
        .rec_bad     (rec_bad),
        .done        (scan_done)
    );

    ibt_table #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .MAX_BAD   (MAX_BAD)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_blk   (rec_blk),
        .rec_bad   (rec_bad),
        .mark_valid(mark_valid),
        .mark_blk  (mark_blk),
        .ready     (scan_done),
        .query_blk (query_blk),
        .query_bad (query_bad),
        .bad_count (bad_count),
        .bad_alert (bad_alert)
    );

    assign query_ready = scan_done;
endmodule

// File: rtl/ibt_scanner_chk.sv
`timescale 1ns/1ps
module ibt_scanner_chk #(
    parameter int NUM_BLOCKS    = 1024,
    parameter int PAGES_PER_BLK = 16,
    parameter int COL_W         = 10
) (
    input logic                                            clk,
    input logic                                            rst_n,
    input logic                                            rd_req_valid,
    input logic                                            rd_req_ready,
    input logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLK)-1:0] rd_req_row,
    input logic [COL_W-1:0]                                rd_req_col,
    input logic [$clog2(NUM_BLOCKS)-1:0]                   query_blk,
    input logic                                            query_ready,
    input logic                                            query_bad,
    input logic                                            scan_done,
    input logic [$clog2(NUM_BLOCKS+1)-1:0]                 bad_count
);
    localparam int PG_W = $clog2(PAGES_PER_BLK);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_row) && $stable(rd_req_col)); // R4
    AST_TWO_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (int'(rd_req_row[PG_W-1:0]) < 2)); // R1
    AST_BLK0_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        query_blk == '0 |-> !query_bad); // R3
    AST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |-> !query_ready && !query_bad); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !rd_req_valid); // R5
    AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bad_count >= $past(bad_count)); // R7
endmodule

bind ibt_scanner ibt_scanner_chk #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .COL_W        (COL_W)
) u_chk (.*);

// File: tb/tb_ibt_scanner.sv
`timescale 1ns/1ps
module tb_ibt_scanner;
    localparam int NB  = 1024;
    localparam int COL = 517;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_req_valid;
    logic        rd_req_ready;
    logic [13:0] rd_req_row;
    logic [9:0]  rd_req_col;
    logic        rd_rsp_valid;
    logic [7:0]  rd_rsp_data;
    logic        mark_valid;
    logic [9:0]  mark_blk;
    logic [9:0]  query_blk;
    logic        query_ready;
    logic        query_bad;
    logic        scan_done;
    logic [10:0] bad_count;
    logic        bad_alert;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int pat = 0;
    int nbad = 0;
    int lat = 0;
    bit throttle = 0;

    always #2.5 clk = ~clk;

    ibt_scanner dut (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .mark_valid(mark_valid), .mark_blk(mark_blk),
        .query_blk(query_blk), .query_ready(query_ready), .query_bad(query_bad),
        .scan_done(scan_done), .bad_count(bad_count), .bad_alert(bad_alert)
    );

    function automatic logic [7:0] model(logic [13:0] row, logic [9:0] col);
        int b = int'(row) / 16;
        int p = int'(row) % 16;
        if (int'(col) != COL) return 8'h00;
        if (pat == 0) begin
            if (p == 0 && (b == 0 || b == 5 || b == 1023)) return 8'h00;
            if (p == 1 && (b == 0 || b == 7 || b == 512)) return 8'h00;
            if (p == 0 && b == 9) return 8'h7F;
            if (p == 2 && b == 11) return 8'h00;
            return 8'hFF;
        end
        if (p == 0 && b >= 100 && b < 100 + nbad) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic bit exp_bad(int b);
        if (b == 0) return 1'b0;
        if (pat == 0) return (b == 5 || b == 7 || b == 9 || b == 512 || b == 1023);
        return (b >= 100 && b < 100 + nbad);
    endfunction

    // read-port model: order check, latency, throttling
    logic [13:0] p_row;
    logic [9:0]  p_col;
    bit          busy;
    int          cnt;
    int          req_idx;
    int          seq_err;
    int          cyc;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_req_ready <= throttle ? (cyc % 3 != 0) : 1'b1;
        rd_rsp_valid <= 1'b0;
        if (!rst_n) begin
            busy <= 0; req_idx <= 0; seq_err <= 0; cnt <= 0;
        end else if (busy) begin
            if (cnt == 0) begin
                rd_rsp_valid <= 1'b1;
                rd_rsp_data  <= model(p_row, p_col);
                busy <= 0;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (rd_req_valid && rd_req_ready) begin
            if (int'(rd_req_row) != (req_idx / 2) * 16 + (req_idx % 2) || int'(rd_req_col) != COL)
                seq_err <= seq_err + 1;
            req_idx <= req_idx + 1;
            busy <= 1; cnt <= lat;
            p_row <= rd_req_row; p_col <= rd_req_col;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mark_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(scan_done == 0, "R5 done low in reset", scan_done, 0);
        chk(bad_count == 0, "R7 count zero in reset", bad_count, 0);
        chk(query_ready == 0, "R6 not ready in reset", query_ready, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        while (!scan_done) @(negedge clk);
    endtask

    task automatic run_scan(input int p, input int nb, input int l, input bit th, input int expcnt);
        pat = p; nbad = nb; lat = l; throttle = th;
        do_reset();
        repeat (100) @(negedge clk);
        query_blk = 10'd5;
        #0.5;
        chk(query_ready == 0 && query_bad == 0, "R6 lookup during scan",
            int'({query_ready, query_bad}), 0);
        wait_done();
        chk(req_idx == 2 * NB, "R1 request count", req_idx, 2 * NB);
        chk(seq_err == 0, "R1 row and column order", seq_err, 0);
        chk(bad_count == 11'(expcnt), "R7 invalid count", bad_count, expcnt);
        chk(bad_alert == (expcnt > 10), "R7 alert level", bad_alert, int'(expcnt > 10));
        for (int b = 0; b < NB; b++) begin
            query_blk = 10'(b);
            #0.1;
            chk(query_ready && query_bad == exp_bad(b),
                b == 0 ? "R3 block 0 valid" : "R2 table entry", query_bad, int'(exp_bad(b)));
        end
        repeat (5) @(negedge clk);
        chk(scan_done && !rd_req_valid && req_idx == 2 * NB, "R5 done holds, no requests",
            req_idx, 2 * NB);
    endtask

    task automatic mark(input int b, input int expcnt, input bit expbad, input string req);
        mark_blk = 10'(b);
        mark_valid = 1'b1;
        @(negedge clk);
        mark_valid = 1'b0;
        query_blk = 10'(b);
        #0.1;
        chk(query_bad == expbad, req, query_bad, int'(expbad));
        chk(bad_count == 11'(expcnt), req, bad_count, expcnt);
    endtask

    task automatic test_boundary();
        run_scan(1, 10, 0, 0, 10);  // R7 exactly at limit, no alert
        mark(20, 11, 1, "R8 mark raises count");
        chk(bad_alert == 1, "R7 alert above limit", bad_alert, 1);
    endtask

    task automatic test_patterns_stalled();
        run_scan(0, 0, 3, 1, 5);    // R2 R4 00h/7Fh markers on either page, stalled port
        mark(20, 6, 1, "R8 new mark");
        mark(20, 6, 1, "R8 repeat mark no count");
        mark(5, 6, 1, "R8 already invalid no count");
        mark(0, 6, 0, "R3 block 0 mark ignored");
        chk(bad_alert == 0, "R7 alert low", bad_alert, 0);
    endtask

    task automatic test_many();
        run_scan(1, 11, 0, 0, 11);  // R7 one over limit
    endtask

    initial begin
        rst_n = 1'b0;
        mark_valid = 1'b0;
        mark_blk = '0;
        query_blk = '0;
        test_boundary();
        test_patterns_stalled();
        test_many();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule